// File: doc/BRIEF.md
# Keyed Flash Mode-Entry Controller

This register block guards the operating-mode changes of an on-chip flash array. It holds two registers: a 16-bit mode-entry register that selects read mode, code-area program/erase mode or data-area program/erase mode, and an 8-bit mode-control register that carries the array's internal operating code. A downstream flash sequencer takes the selected program/erase mode from `pe_mode` and the operating code from `mode_ctrl`.

Neither register behaves as a plain store. A mode-entry write needs a key byte in its upper half. A mode-control value is taken only after a protect key, the value, its bitwise inverse and the value again have been written in strict order. A write that breaks the order aborts the sequence and raises a sticky error flag. The block also refuses to return to read mode straight from a code-area program/erase code, so software has to pass through the discharge steps first. After every accepted mode change a settle counter holds `ready` low. The setup interval is programmable, with a separate and shorter interval for low-voltage codes.

Register addresses on `wr_addr`/`rd_addr` are: 0 = mode-entry, 1 = mode-control, 2 = protect. Address 3 is unmapped.

Top module: `flash_mode_guard`

## Requirements
- R1: A write to the mode-entry register (address 0) takes effect only if it is a halfword write (`wr_half`=1) whose upper byte is 0xAA. Byte writes and halfword writes with any other upper byte leave `pe_mode` and the register contents unchanged.
- R2: A keyed mode-entry write whose low byte is 0x01 sets `pe_mode` to 2'b01 (code area). A low byte of 0x80 sets it to 2'b10 (data area). A low byte of 0x00 sets it to 2'b00 (read). A keyed write with any other low byte is ignored. `pe_mode` never takes the value 2'b11.
- R3: Reading address 0 returns {8'h00, stored low byte}, so the register reads 0x0000 once read mode has been entered. Reading address 1 returns {8'h00, `mode_ctrl`}.
- R4: `mode_ctrl` changes only after this exact write sequence: 0xA5 to the protect register (address 2), then a value V, then ~V, then V again, each to address 1 (low byte used). The new value appears in the cycle after the last write.
- R5: While a sequence is in progress, any write that is not the expected next one aborts it. This covers a wrong inverse, a wrong repeat, or a write to address 0, 2 or 3. On an abort `mode_ctrl` is unchanged and `seq_err` is set. `seq_err` stays set until reset.
- R6: The protect key arms only the next write. A write to address 1 while the sequence is not armed is ignored and sets `seq_err`.
- R7: A completed sequence whose value, ignoring bit 6, is 0x08 (read) is rejected, with `mode_ctrl` unchanged and `seq_err` set, when the current `mode_ctrl` value ignoring bit 6 is 0x02, 0x82 or 0x92. Bit 6 (0x40) marks a low-voltage code.
- R8: After an accepted mode-control change, `ready` is low for exactly `settle_lv` cycles if bit 6 of the new value is set, and for `settle_nom` cycles otherwise. After an accepted mode-entry write it is low for `settle_nom` cycles. A new change reloads the counter.
- R9: After reset `pe_mode` is 2'b00, `mode_ctrl` is 0x08, `ready` is 1 and `seq_err` is 0.
- R10: Reading the protect register (address 2) or the unmapped address 3 returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Write register address |
| wr_half | input | 1 | 1 = halfword write, 0 = byte write |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Combinational read data |
| settle_nom | input | CNT_W | Settle length in cycles for normal changes |
| settle_lv | input | CNT_W | Settle length in cycles for low-voltage codes |
| pe_mode | output | 2 | Program/erase mode to the sequencer |
| mode_ctrl | output | 8 | Current mode-control code |
| ready | output | 1 | High when no settle interval is running |
| seq_err | output | 1 | Sticky unlock-sequence error |

## Verification
Mode-entry writes are applied with the correct key, with a wrong key, as byte writes and with illegal low bytes. These patterns separate a missing key check from a missing legality check. The unlock sequence is driven complete, cut short, with a corrupt inverse, with no arming write, and with a foreign write between steps. These patterns show that only the full four-write order commits and that each abort path raises the error. The discharge path is run both in the allowed order (0x02, 0x92, 0x12, 0x08) and with shortcuts from 0x02 and 0x92 straight to 0x08. The settle length is measured for a normal code, a low-voltage code and a mode-entry change, which distinguishes the two interval inputs.

// File: rtl/fmg_pkg.sv
package fmg_pkg;
  localparam int          ADDR_W    = 2;
  localparam logic [1:0]  A_ENTRY   = 2'd0;
  localparam logic [1:0]  A_CTRL    = 2'd1;
  localparam logic [1:0]  A_PROT    = 2'd2;
  localparam logic [7:0]  ENTRY_KEY = 8'hAA;
  localparam logic [7:0]  PROT_KEY  = 8'hA5;
  localparam logic [7:0]  MC_READ   = 8'h08;
  localparam logic [7:0]  MC_LV     = 8'h40;

  typedef enum logic [1:0] {
    PE_READ = 2'b00,
    PE_CODE = 2'b01,
    PE_DATA = 2'b10
  } pe_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ARMED,
    SQ_VAL,
    SQ_INV
  } seq_st_e;
endpackage

// File: rtl/fmg_entry_reg.sv
module fmg_entry_reg
  import fmg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_hit,
  input  logic        wr_half,
  input  logic [15:0] wr_data,
  output logic [7:0]  entry_q,
  output logic        accept
);
  logic       key_ok;
  logic       legal;
  logic [7:0] entry_n;

  always_comb begin
    key_ok  = wr_en && wr_hit && wr_half && (wr_data[15:8] == ENTRY_KEY);
    legal   = (wr_data[7:0] == 8'h00) || (wr_data[7:0] == 8'h01) ||
              (wr_data[7:0] == 8'h80);
    accept  = key_ok && legal;
    entry_n = accept ? wr_data[7:0] : entry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      entry_q <= 8'h00;
    else if (accept) entry_q <= entry_n;
  end
endmodule

// File: rtl/fmg_unlock_seq.sv
module fmg_unlock_seq
  import fmg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       hit_ctrl,
  input  logic       hit_prot,
  input  logic [7:0] wdat,
  output logic [7:0] mctl_q,
  output logic       commit,
  output logic       commit_lv,
  output logic       err_q
);
  seq_st_e    st_q, st_n;
  logic [7:0] cand_q, cand_n;
  logic [7:0] mctl_n;
  logic       err_set;
  logic       blocked;
  logic [7:0] cur_m;

  always_comb begin
    cur_m   = mctl_q & ~MC_LV;
    blocked = ((cand_q & ~MC_LV) == MC_READ) &&
              ((cur_m == 8'h02) || (cur_m == 8'h82) || (cur_m == 8'h92));
  end

  always_comb begin
    st_n    = st_q;
    cand_n  = cand_q;
    mctl_n  = mctl_q;
    err_set = 1'b0;
    commit  = 1'b0;
    if (wr_en) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (hit_prot && (wdat == PROT_KEY)) st_n = SQ_ARMED;
          else if (hit_ctrl)                  err_set = 1'b1;
        end
        SQ_ARMED: begin
          if (hit_ctrl) begin
            cand_n = wdat;
            st_n   = SQ_VAL;
          end else begin
            err_set = 1'b1;
            st_n    = SQ_IDLE;
          end
        end
        SQ_VAL: begin
          if (hit_ctrl && (wdat == ~cand_q)) st_n = SQ_INV;
          else begin
            err_set = 1'b1;
            st_n    = SQ_IDLE;
          end
        end
        SQ_INV: begin
          st_n = SQ_IDLE;
          if (hit_ctrl && (wdat == cand_q) && !blocked) begin
            commit = 1'b1;
            mctl_n = cand_q;
          end else begin
            err_set = 1'b1;
          end
        end
        default: st_n = SQ_IDLE;
      endcase
    end
    commit_lv = (cand_q & MC_LV) != 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cand_q <= 8'h00;
      mctl_q <= MC_READ;
      err_q  <= 1'b0;
    end else begin
      if (wr_en)   st_q   <= st_n;
      if (wr_en)   cand_q <= cand_n;
      if (commit)  mctl_q <= mctl_n;
      if (err_set) err_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/fmg_settle_timer.sv
module fmg_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             ready
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_n  = start ? len : cnt_q - 1'b1;
    ready  = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/flash_mode_guard.sv
module flash_mode_guard
  import fmg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic             wr_half,
  input  logic [15:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [15:0]      rd_data,
  input  logic [CNT_W-1:0] settle_nom,
  input  logic [CNT_W-1:0] settle_lv,
  output logic [1:0]       pe_mode,
  output logic [7:0]       mode_ctrl,
  output logic             ready,
  output logic             seq_err
);
  logic [7:0]       entry_q;
  logic             entry_acc;
  logic             mc_commit;
  logic             mc_lv;
  logic             st_start;
  logic [CNT_W-1:0] st_len;

  fmg_entry_reg u_entry (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_hit  (wr_addr == A_ENTRY),
    .wr_half (wr_half),
    .wr_data (wr_data),
    .entry_q (entry_q),
    .accept  (entry_acc)
  );

  fmg_unlock_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .hit_ctrl  (wr_addr == A_CTRL),
    .hit_prot  (wr_addr == A_PROT),
    .wdat      (wr_data[7:0]),
    .mctl_q    (mode_ctrl),
    .commit    (mc_commit),
    .commit_lv (mc_lv),
    .err_q     (seq_err)
  );

  always_comb begin
    st_start = mc_commit || entry_acc;
    st_len   = (mc_commit && mc_lv) ? settle_lv : settle_nom;
  end

  fmg_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (st_start),
    .len   (st_len),
    .ready (ready)
  );

  always_comb begin
    if (entry_q[0])      pe_mode = PE_CODE;
    else if (entry_q[7]) pe_mode = PE_DATA;
    else                 pe_mode = PE_READ;
  end

  always_comb begin
    unique case (rd_addr)
      A_ENTRY: rd_data = {8'h00, entry_q};
      A_CTRL:  rd_data = {8'h00, mode_ctrl};
      default: rd_data = 16'h0000;
    endcase
  end
endmodule

// File: rtl/fmg_checker.sv
module fmg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             wr_half,
  input logic [15:0]      wr_data,
  input logic [CNT_W-1:0] settle_nom,
  input logic [CNT_W-1:0] settle_lv,
  input logic [1:0]       pe_mode,
  input logic [7:0]       mode_ctrl,
  input logic             ready,
  input logic             seq_err
);
  a_r1_unkeyed_entry_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && (!wr_half || wr_data[15:8] != 8'hAA))
      |=> $stable(pe_mode));

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pe_mode != 2'b11);

  a_r4_ctrl_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ctrl != $past(mode_ctrl)) |-> $past(wr_en && wr_addr == 2'd1));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  a_r8_busy_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_ctrl != $past(mode_ctrl)) && settle_nom != '0 && settle_lv != '0)
      |-> !ready);
endmodule

bind flash_mode_guard fmg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_half    (wr_half),
  .wr_data    (wr_data),
  .settle_nom (settle_nom),
  .settle_lv  (settle_lv),
  .pe_mode    (pe_mode),
  .mode_ctrl  (mode_ctrl),
  .ready      (ready),
  .seq_err    (seq_err)
);

// File: tb/tb_flash_mode_guard.sv
module tb_flash_mode_guard;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int NOM        = 5;
  localparam int LV         = 3;

  logic             clk;
  logic             rst_n;
  logic             wr_en;
  logic [1:0]       wr_addr;
  logic             wr_half;
  logic [15:0]      wr_data;
  logic [1:0]       rd_addr;
  logic [15:0]      rd_data;
  logic [CNT_W-1:0] settle_nom;
  logic [CNT_W-1:0] settle_lv;
  logic [1:0]       pe_mode;
  logic [7:0]       mode_ctrl;
  logic             ready;
  logic             seq_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  flash_mode_guard #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_half(wr_half), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .settle_nom(settle_nom), .settle_lv(settle_lv),
    .pe_mode(pe_mode), .mode_ctrl(mode_ctrl), .ready(ready),
    .seq_err(seq_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic h);
    wr_addr = a; wr_data = d; wr_half = h; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic unlock(input logic [7:0] v);
    wr(2'd2, 16'h00A5, 1'b0);
    wr(2'd1, {8'h00, v}, 1'b0);
    wr(2'd1, {8'h00, ~v}, 1'b0);
    wr(2'd1, {8'h00, v}, 1'b0);
  endtask

  task automatic settle_len(output int n);
    n = 0;
    while (!ready && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset_state();
    logic [15:0] d;
    do_reset();
    chk("R9 pe_mode", {14'd0, pe_mode}, 16'h0000);
    chk("R9 mode_ctrl", {8'd0, mode_ctrl}, 16'h0008);
    chk("R9 ready", {15'd0, ready}, 16'h0001);
    chk("R9 seq_err", {15'd0, seq_err}, 16'h0000);
    rd(2'd0, d);
    chk("R3 entry readback at reset", d, 16'h0000);
  endtask

  task automatic t_entry_keyed();
    logic [15:0] d;
    int n;
    wr(2'd0, 16'hAA01, 1'b1);
    chk("R2 code mode", {14'd0, pe_mode}, 16'h0001);
    rd(2'd0, d);
    chk("R3 entry readback code", d, 16'h0001);
    settle_len(n);
    chk("R8 entry settle", n[15:0], NOM);
    wr(2'd0, 16'hAA80, 1'b1);
    chk("R2 data mode", {14'd0, pe_mode}, 16'h0002);
    wr(2'd0, 16'hAA00, 1'b1);
    chk("R2 back to read", {14'd0, pe_mode}, 16'h0000);
    rd(2'd0, d);
    chk("R3 entry reads zero in read mode", d, 16'h0000);
  endtask

  task automatic t_entry_unkeyed();
    logic [15:0] d;
    wr(2'd0, 16'h0001, 1'b0);
    chk("R1 byte write ignored", {14'd0, pe_mode}, 16'h0000);
    wr(2'd0, 16'h5580, 1'b1);
    chk("R1 wrong key ignored", {14'd0, pe_mode}, 16'h0000);
    wr(2'd0, 16'hAA81, 1'b1);
    rd(2'd0, d);
    chk("R2 illegal low byte ignored", d, 16'h0000);
  endtask

  task automatic t_unlock_ok();
    logic [15:0] d;
    int n;
    unlock(8'h10);
    chk("R4 mode_ctrl committed", {8'd0, mode_ctrl}, 16'h0010);
    chk("R4 no error", {15'd0, seq_err}, 16'h0000);
    rd(2'd1, d);
    chk("R3 ctrl readback", d, 16'h0010);
    settle_len(n);
    chk("R8 nominal settle", n[15:0], NOM);
    unlock(8'h50);
    chk("R4 lv value committed", {8'd0, mode_ctrl}, 16'h0050);
    settle_len(n);
    chk("R8 low-voltage settle", n[15:0], LV);
    rd(2'd2, d);
    chk("R10 protect reads zero", d, 16'h0000);
    rd(2'd3, d);
    chk("R10 unmapped reads zero", d, 16'h0000);
  endtask

  task automatic t_partial_and_bad_inverse();
    do_reset();
    wr(2'd2, 16'h00A5, 1'b0);
    wr(2'd1, 16'h0010, 1'b0);
    wr(2'd1, 16'h00EF, 1'b0);
    chk("R4 three writes do not commit", {8'd0, mode_ctrl}, 16'h0008);
    chk("R4 no error yet", {15'd0, seq_err}, 16'h0000);
    wr(2'd1, 16'h0011, 1'b0);
    chk("R5 wrong repeat keeps value", {8'd0, mode_ctrl}, 16'h0008);
    chk("R5 wrong repeat flags error", {15'd0, seq_err}, 16'h0001);
    do_reset();
    wr(2'd2, 16'h00A5, 1'b0);
    wr(2'd1, 16'h0010, 1'b0);
    wr(2'd1, 16'h00EE, 1'b0);
    wr(2'd1, 16'h0010, 1'b0);
    chk("R5 bad inverse keeps value", {8'd0, mode_ctrl}, 16'h0008);
    chk("R5 bad inverse flags error", {15'd0, seq_err}, 16'h0001);
    unlock(8'h10);
    chk("R5 error stays sticky", {15'd0, seq_err}, 16'h0001);
  endtask

  task automatic t_unarmed_and_intervening();
    do_reset();
    wr(2'd1, 16'h0010, 1'b0);
    wr(2'd1, 16'h00EF, 1'b0);
    wr(2'd1, 16'h0010, 1'b0);
    chk("R6 unarmed ctrl write ignored", {8'd0, mode_ctrl}, 16'h0008);
    chk("R6 unarmed ctrl write flags error", {15'd0, seq_err}, 16'h0001);
    do_reset();
    wr(2'd2, 16'h00A5, 1'b0);
    wr(2'd0, 16'h1234, 1'b1);
    wr(2'd1, 16'h0010, 1'b0);
    wr(2'd1, 16'h00EF, 1'b0);
    wr(2'd1, 16'h0010, 1'b0);
    chk("R5 intervening write aborts", {8'd0, mode_ctrl}, 16'h0008);
    chk("R5 intervening write flags error", {15'd0, seq_err}, 16'h0001);
  endtask

  task automatic t_discharge_order();
    do_reset();
    unlock(8'h02);
    unlock(8'h08);
    chk("R7 code to read rejected", {8'd0, mode_ctrl}, 16'h0002);
    chk("R7 code to read flags error", {15'd0, seq_err}, 16'h0001);
    do_reset();
    unlock(8'h02);
    unlock(8'h92);
    unlock(8'h48);
    chk("R7 discharge1 to read rejected", {8'd0, mode_ctrl}, 16'h0092);
    do_reset();
    unlock(8'h02);
    unlock(8'h92);
    unlock(8'h12);
    unlock(8'h08);
    chk("R7 full discharge path reaches read", {8'd0, mode_ctrl}, 16'h0008);
    chk("R7 full discharge path no error", {15'd0, seq_err}, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_half = 1'b0;
    wr_data = '0; rd_addr = '0;
    settle_nom = NOM; settle_lv = LV;
    t_reset_state();
    t_entry_keyed();
    t_entry_unkeyed();
    t_unlock_ok();
    t_partial_and_bad_inverse();
    t_unarmed_and_intervening();
    t_discharge_order();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule